// File: doc/BRIEF.md
# Compressed Register-Pair Access Expander

This block sits in the instruction-fetch path of a 32-bit core that supports 64-bit loads and stores through even/odd register pairs. It takes one 16-bit compressed instruction and, in the same cycle, produces the equivalent 32-bit load-pair or store-pair encoding. Four compressed forms are recognised: a load and a store whose base is the stack pointer (x2), and a load and a store whose base and data registers come from the 3-bit compact register fields. All other 16-bit inputs leave the match flag low so that a neighbouring expander can handle them.

The unit is purely combinational and has no clock or reset. Internally a form decoder classifies the word, a field extractor pulls out base register, data register and byte offset, a legality check rejects reserved encodings, and a word builder assembles the 32-bit result. The state-machine style of the code base does not apply here because nothing is stored; the four forms play the part of states, and the decoder's choice among them is the only transition.

Top module: `cpx_pair_expander`

## Requirements
- R1: When `en` is 0, `match`, `illegal` and `xinstr` are all 0 whatever `cinstr` holds.
- R2: With `en` at 1, an input whose bits [1:0] are not 00 or 10, or whose bits [15:13] are neither 011 nor 111, gives `match`=0, `illegal`=0 and `xinstr`=0.
- R3: Stack load (bits [1:0]=10, bits [15:13]=011): data register is bits [11:7]; offset bit 5 is bit 12, offset bits 4:3 are bits 6:5, offset bits 8:6 are bits 4:2, low three offset bits are 0. The output is the load word {offset[11:0], base=x2, 3'b011, rd, 7'h03}.
- R4: Stack store (bits [1:0]=10, bits [15:13]=111): data register is bits [6:2]; offset bits 5:3 are bits 12:10 and offset bits 8:6 are bits 9:7. The output is the store word {offset[11:5], rs2, base=x2, 3'b011, offset[4:0], 7'h23}.
- R5: Register load (bits [1:0]=00, bits [15:13]=011): base is bits [9:7], data register bits [4:2]; offset bits 5:3 are bits 12:10 and offset bits 7:6 are bits 6:5. The output is the load word of R3 with that base.
- R6: Register store (bits [1:0]=00, bits [15:13]=111): same field layout as R5, bits [4:2] naming the source register; the output is the store word of R4 with that base.
- R7: A stack load naming x0 as data register gives `match`=1, `illegal`=1, `xinstr`=0.
- R8: An odd data register number in any of the four forms gives `match`=1, `illegal`=1, `xinstr`=0.
- R9: Offsets are zero-extended multiples of 8, so the largest offsets (504 for the stack forms, 248 for the register forms) appear positive in the 12-bit immediate.
- R10: A 3-bit compact register field r names register 8+r (binary 01 prefixed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en | input | 1 | Expansion enable |
| cinstr | input | 16 | Compressed instruction word |
| xinstr | output | 32 | Expanded 32-bit instruction, 0 when not a legal match |
| match | output | 1 | Input is one of the four pair forms |
| illegal | output | 1 | Matched form uses a reserved register choice |

## Verification
The hardest cases to reach are the reserved encodings mixed with extreme offsets: an odd data register inside a stack load whose offset is 504, or x0 in a stack load next to the otherwise identical legal x2 encoding. Rather than aiming at them one by one, the bench sweeps all 65,536 input words with the enable set, so every register choice, every offset bit and every neighbouring quadrant and function code is applied, and then repeats a spread of words with the enable cleared.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
    localparam int CW   = 16;
    localparam int XW   = 32;
    localparam int RW   = 5;
    localparam int CRW  = 3;
    localparam int OFFW = 12;

    localparam logic [6:0]     OPC_LOAD   = 7'h03;
    localparam logic [6:0]     OPC_STORE  = 7'h23;
    localparam logic [2:0]     F3_PAIR    = 3'b011;
    localparam logic [1:0]     Q_REG      = 2'b00;
    localparam logic [1:0]     Q_SP       = 2'b10;
    localparam logic [2:0]     CF3_LOAD   = 3'b011;
    localparam logic [2:0]     CF3_STORE  = 3'b111;
    localparam logic [RW-1:0]  SP_REG     = 5'd2;
    localparam logic [RW-1:0]  ZERO_REG   = 5'd0;
    localparam logic [RW-CRW-1:0] COMPACT_HI = 2'b01;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_SP_LOAD,
        FORM_SP_STORE,
        FORM_REG_LOAD,
        FORM_REG_STORE
    } pair_form_e;

    typedef struct packed {
        logic [RW-1:0]   base;
        logic [RW-1:0]   data;
        logic [OFFW-1:0] offset;
    } pair_fields_t;
endpackage

// File: rtl/cpx_form_decode.sv
module cpx_form_decode
    import cpx_pkg::*;
(
    input  logic       en,
    input  logic [2:0] funct3,
    input  logic [1:0] quadrant,
    output pair_form_e form
);
    always_comb begin
        form = FORM_NONE;
        if (en) begin
            unique case ({funct3, quadrant})
                {CF3_LOAD,  Q_SP}:  form = FORM_SP_LOAD;
                {CF3_STORE, Q_SP}:  form = FORM_SP_STORE;
                {CF3_LOAD,  Q_REG}: form = FORM_REG_LOAD;
                {CF3_STORE, Q_REG}: form = FORM_REG_STORE;
                default:            form = FORM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cpx_field_extract.sv
module cpx_field_extract
    import cpx_pkg::*;
(
    input  pair_form_e   form,
    input  logic [12:2]  body,
    output pair_fields_t fields
);
    logic [RW-1:0] compact_base;
    logic [RW-1:0] compact_data;

    assign compact_base = {COMPACT_HI, body[9:7]};
    assign compact_data = {COMPACT_HI, body[4:2]};

    always_comb begin
        fields = '0;
        unique case (form)
            FORM_SP_LOAD: begin
                fields.base   = SP_REG;
                fields.data   = body[11:7];
                fields.offset = {3'b000, body[4:2], body[12], body[6:5], 3'b000};
            end
            FORM_SP_STORE: begin
                fields.base   = SP_REG;
                fields.data   = body[6:2];
                fields.offset = {3'b000, body[9:7], body[12:10], 3'b000};
            end
            FORM_REG_LOAD, FORM_REG_STORE: begin
                fields.base   = compact_base;
                fields.data   = compact_data;
                fields.offset = {4'b0000, body[6:5], body[12:10], 3'b000};
            end
            default: fields = '0;
        endcase
    end
endmodule

// File: rtl/cpx_legality.sv
module cpx_legality
    import cpx_pkg::*;
(
    input  pair_form_e    form,
    input  logic [RW-1:0] data_reg,
    output logic          illegal
);
    logic odd_pair;
    logic zero_dest;

    assign odd_pair  = data_reg[0];
    assign zero_dest = (form == FORM_SP_LOAD) && (data_reg == ZERO_REG);

    always_comb begin
        illegal = 1'b0;
        if (form != FORM_NONE) begin
            illegal = odd_pair || zero_dest;
        end
    end
endmodule

// File: rtl/cpx_word_build.sv
module cpx_word_build
    import cpx_pkg::*;
(
    input  pair_form_e    form,
    input  pair_fields_t  fields,
    input  logic          illegal,
    output logic [XW-1:0] word
);
    always_comb begin
        word = '0;
        if (!illegal) begin
            unique case (form)
                FORM_SP_LOAD, FORM_REG_LOAD:
                    word = {fields.offset, fields.base, F3_PAIR, fields.data, OPC_LOAD};
                FORM_SP_STORE, FORM_REG_STORE:
                    word = {fields.offset[11:5], fields.data, fields.base, F3_PAIR,
                            fields.offset[4:0], OPC_STORE};
                default:
                    word = '0;
            endcase
        end
    end
endmodule

// File: rtl/cpx_pair_expander.sv
module cpx_pair_expander
    import cpx_pkg::*;
(
    input  logic          en,
    input  logic [CW-1:0] cinstr,
    output logic [XW-1:0] xinstr,
    output logic          match,
    output logic          illegal
);
    pair_form_e   form;
    pair_fields_t fields;
    logic         reserved;

    cpx_form_decode u_decode (
        .en       (en),
        .funct3   (cinstr[15:13]),
        .quadrant (cinstr[1:0]),
        .form     (form)
    );

    cpx_field_extract u_extract (
        .form   (form),
        .body   (cinstr[12:2]),
        .fields (fields)
    );

    cpx_legality u_legal (
        .form     (form),
        .data_reg (fields.data),
        .illegal  (reserved)
    );

    cpx_word_build u_build (
        .form    (form),
        .fields  (fields),
        .illegal (reserved),
        .word    (xinstr)
    );

    assign match   = (form != FORM_NONE);
    assign illegal = reserved;
endmodule

// File: rtl/cpx_pair_expander_chk.sv
module cpx_pair_expander_chk (
    input logic        en,
    input logic [15:0] cinstr,
    input logic [31:0] xinstr,
    input logic        match,
    input logic        illegal
);
    logic legal;
    assign legal = match && !illegal;

    always_comb begin
        if (!$isunknown({en, cinstr})) begin
            p_disabled_quiet_r1: assert (en || (!match && !illegal && xinstr == 32'd0));
            p_other_quadrant_r2: assert (!(cinstr[1:0] == 2'b01 || cinstr[1:0] == 2'b11) || !match);
            p_sp_base_r3: assert (!(legal && cinstr[1:0] == 2'b10) || xinstr[19:15] == 5'd2);
            p_sp_load_dest_r7: assert (!(legal && cinstr[1:0] == 2'b10 && cinstr[15:13] == 3'b011)
                                       || (xinstr[11:7] == cinstr[11:7] && cinstr[11:7] != 5'd0));
            p_pair_width_r4: assert (!legal || (xinstr[14:12] == 3'b011
                                     && (xinstr[6:0] == 7'h03 || xinstr[6:0] == 7'h23)));
            p_reserved_zero_r8: assert (!illegal || (match && xinstr == 32'd0));
            p_even_dest_r8: assert (!(legal && xinstr[6:0] == 7'h03) || !xinstr[7]);
            p_compact_base_r10: assert (!(legal && cinstr[1:0] == 2'b00)
                                        || xinstr[19:15] == {2'b01, cinstr[9:7]});
            p_reg_load_fields_r5: assert (!(legal && cinstr[1:0] == 2'b00 && cinstr[15:13] == 3'b011)
                                          || (xinstr[9:7] == cinstr[4:2] && xinstr[11:10] == 2'b01
                                              && xinstr[27:23] == {cinstr[6:5], cinstr[12:10]}));
            p_reg_store_src_r6: assert (!(legal && cinstr[1:0] == 2'b00 && cinstr[15:13] == 3'b111)
                                        || xinstr[24:20] == {2'b01, cinstr[4:2]});
            p_zero_extend_r9: assert (!legal || !xinstr[31]);
        end
    end
endmodule

bind cpx_pair_expander cpx_pair_expander_chk u_chk (
    .en      (en),
    .cinstr  (cinstr),
    .xinstr  (xinstr),
    .match   (match),
    .illegal (illegal)
);

// File: tb/test_cpx_pair_expander.sv
module test_cpx_pair_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] cinstr = 16'h0000;
    logic [31:0] xinstr;
    logic        match;
    logic        illegal;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpx_pair_expander i_cpx_pair_expander (
        .en      (en),
        .cinstr  (cinstr),
        .xinstr  (xinstr),
        .match   (match),
        .illegal (illegal)
    );

    // Behavioural model: integer arithmetic on offsets and register numbers.
    task automatic model(input bit e, input logic [15:0] c, output logic [33:0] exp, output string tag);
        int q, f, dreg, base, off, maxoff, w;
        bit is_load, hit, bad;
        q = int'(c[1:0]);
        f = int'(c[15:13]);
        hit = 0; is_load = 0; dreg = 0; base = 0; off = 0; maxoff = 0;
        tag = "R2";
        if (!e) begin
            tag = "R1";
        end else if (q == 2 && (f == 3 || f == 7)) begin
            hit = 1; base = 2; maxoff = 504;
            if (f == 3) begin
                is_load = 1; tag = "R3";
                dreg = int'(c[11:7]);
                off = int'(c[12]) * 32 + int'(c[6:5]) * 8 + int'(c[4:2]) * 64;
            end else begin
                tag = "R4";
                dreg = int'(c[6:2]);
                off = int'(c[12:10]) * 8 + int'(c[9:7]) * 64;
            end
        end else if (q == 0 && (f == 3 || f == 7)) begin
            hit = 1; maxoff = 248;
            is_load = (f == 3);
            tag = is_load ? "R5,R10" : "R6,R10";
            dreg = 8 + int'(c[4:2]);
            base = 8 + int'(c[9:7]);
            off = int'(c[12:10]) * 8 + int'(c[6:5]) * 64;
        end
        bad = 0;
        if (hit && is_load && q == 2 && dreg == 0) begin bad = 1; tag = "R7"; end
        else if (hit && (dreg % 2) == 1) begin bad = 1; tag = "R8"; end
        if (hit && !bad && off == maxoff) tag = {tag, ",R9"};
        w = 0;
        if (hit && !bad) begin
            if (is_load)
                w = off * (1 << 20) + base * (1 << 15) + 3 * 4096 + dreg * 128 + 3;
            else
                w = (off / 32) * (1 << 25) + dreg * (1 << 20) + base * (1 << 15)
                    + 3 * 4096 + (off % 32) * 128 + 35;
        end
        exp = {hit, bad, 32'(w)};
    endtask

    task automatic compare(input logic [33:0] exp, input string tag);
        vectors++;
        if ({match, illegal, xinstr} !== exp) begin
            miscompares++;
            $display("FAIL %s cinstr=%h en=%b: actual match=%b illegal=%b xinstr=%h expected match=%b illegal=%b xinstr=%h",
                     tag, cinstr, en, match, illegal, xinstr, exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic apply(input bit e, input logic [15:0] c);
        logic [33:0] exp;
        string tag;
        @(posedge clk);
        #1;
        en = e;
        cinstr = c;
        @(negedge clk);
        model(e, c, exp, tag);
        compare(exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // Reset window: enable low, outputs quiet (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(34'd0, "R1 reset");
        rst_n = 1'b1;

        // Hand-worked case: stack load x10 at offset 504 -> 0x1F813503 (R3, R9).
        apply(1'b1, 16'h757E);
        vectors++;
        if ({match, illegal, xinstr} !== {2'b10, 32'h1F813503}) begin
            miscompares++;
            $display("FAIL R3,R9 literal: actual %b%b %h expected 10 1f813503", match, illegal, xinstr);
        end

        // Same word with x0 destination is reserved (R7): bits 11:7 cleared.
        apply(1'b1, 16'h707E);
        // Odd destination x11 (R8).
        apply(1'b1, 16'h75FE);

        // Full sweep with enable set: every form, register and offset (R2..R10).
        for (int i = 0; i < 65536; i++) apply(1'b1, 16'(i));

        // Enable cleared over a spread of words, including matching forms (R1).
        for (int i = 0; i < 512; i++) apply(1'b0, 16'(i * 127 + 3));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule